// File: doc/BRIEF.md
# Write Strobe Qualifier with Hardware Write Protection

This block sits between an asynchronous byte-wide host bus and a page programming engine. It watches three active-low controls: chip enable, output enable and write enable. It decides whether a bus cycle is a genuine write. The write strobe is the overlap of chip enable low and write enable low. The address is taken when that overlap begins, which is the later of the two falling edges. The data is taken when the overlap ends, which is the earlier of the two rising edges. Either enable can therefore act as the controlling strobe.

All controls, the address and the data pass through the same synchronizer depth, so they stay aligned inside the clock domain. A write is discarded for any of these reasons:
- the overlap lasts fewer than a set number of clock cycles;
- output enable is low at any point during the overlap;
- the supply-good input is low during the overlap;
- the power-up hold-off has not expired.

The hold-off timer restarts every time supply-good drops. An accepted write appears downstream as a one-cycle pulse, together with the latched address and data. A combinational drive-enable output shows when the host is reading and the data pins may be driven.

Top module: `strobe_guard`

## Requirements
- R1: While rst_ni is low and after its release, wr_pulse_o is 0, and wr_addr_o and wr_data_o are all zeros.
- R2: A write controlled by write enable (chip enable already low, write enable pulsed low) gives exactly one wr_pulse_o. The pulse is high during the cycle that follows the third rising clock edge after the first enable returns high.
- R3: A write controlled by chip enable (write enable already low, chip enable pulsed low) is accepted in the same way, with the same latency.
- R4: wr_addr_o carries the address present when the second of the two enables went low. Address changes later in the strobe are ignored.
- R5: wr_data_o carries the data present in the last cycle before the first enable rose. Earlier data values in the strobe are ignored.
- R6: If output enable is low for any cycle while both enables are low, no pulse is produced, and wr_addr_o and wr_data_o keep their values.
- R7: A strobe overlap shorter than MIN_LOW clock cycles gives no pulse. An overlap of exactly MIN_LOW cycles is accepted.
- R8: While supply_ok_i is low, no write is accepted.
- R9: After supply_ok_i rises, writes stay blocked for HOLD_CYC cycles. The timer restarts whenever supply_ok_i falls.
- R10: wr_pulse_o is never high for two cycles in a row. wr_addr_o and wr_data_o change only in a cycle where wr_pulse_o is high.
- R11: rd_drive_o is 1 exactly when ce_ni and oe_ni are 0 and we_ni is 1. It is combinational from the pins, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | ADDR_W | Host address bus |
| data_i | input | DATA_W | Host write data bus |
| supply_ok_i | input | 1 | Digital supply-good indication |
| wr_pulse_o | output | 1 | One-cycle pulse marking an accepted write |
| wr_addr_o | output | ADDR_W | Address of the last accepted write |
| wr_data_o | output | DATA_W | Data of the last accepted write |
| rd_drive_o | output | 1 | Data pins may be driven for a read |

## Verification
The accept pulse has a latency of three clock edges. Two edges come from the synchronizer and one from the output register. The bench therefore releases the strobe on a falling clock edge, observes six following falling edges, and requires any pulse to appear on exactly the third. This same window also shows that wr_addr_o and wr_data_o hold their values for rejected strobes. The read drive-enable is combinational, so it is sampled one time unit after the pins change. Hold-off is checked by starting a strobe well inside the HOLD_CYC window and again well after it.

// File: rtl/strobe_guard_pkg.sv
package strobe_guard_pkg;
  localparam int unsigned ADDR_W_DEF  = 13;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam int unsigned MIN_LOW_DEF = 3;         // 15 ns at 200 MHz
  localparam int unsigned HOLD_DEF    = 1_000_000; // 5 ms at 200 MHz
  localparam int unsigned SYNC_DEF    = 2;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic pwr_ok;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, pwr_ok: 1'b0};
endpackage

// File: rtl/strobe_guard_sync.sv
module strobe_guard_sync #(
  parameter int unsigned     W       = 4,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/strobe_guard_holdoff.sv
module strobe_guard_holdoff #(
  parameter int unsigned HOLD_CYC = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  output logic wr_en_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!pwr_ok_i)     cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign wr_en_o = pwr_ok_i && (cnt_q == LIMIT);

  // R8/R9: a supply drop removes write permission and restarts the wait
  a_r9_drop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_ok_i) |=> !wr_en_o);
  a_r8_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(pwr_ok_i));
endmodule

// File: rtl/strobe_guard_qual.sv
module strobe_guard_qual #(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_LOW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_pulse_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] MIN_CNT = CW'(MIN_LOW);

  logic              strobe, strobe_q, bad_q, end_ok;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign strobe = !ce_n_i && !we_n_i;
  assign end_ok = strobe_q && !strobe && (cnt_q >= MIN_CNT) && !bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      bad_q    <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe && !strobe_q) begin
        // later falling edge: capture address, start width count
        addr_q <= addr_i;
        cnt_q  <= CW'(1);
        bad_q  <= !oe_n_i || !wr_en_i;
      end else if (strobe) begin
        if (cnt_q < MIN_CNT) cnt_q <= cnt_q + 1'b1;
        if (!oe_n_i || !wr_en_i) bad_q <= 1'b1;
      end
      // keeps tracking until the first rising edge
      if (strobe) data_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pulse_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_pulse_o <= end_ok;
      if (end_ok) begin
        wr_addr_o <= addr_q;
        wr_data_o <= data_q;
      end
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o);
  a_r10_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pulse_o |-> ($stable(wr_addr_o) && $stable(wr_data_o)));
  a_r7_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |-> ($past(cnt_q) >= MIN_CNT));
  a_r6_strobe_ended: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |-> !$past(strobe));
endmodule

// File: rtl/strobe_guard.sv
module strobe_guard
  import strobe_guard_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned MIN_LOW     = MIN_LOW_DEF,
  parameter int unsigned HOLD_CYC    = HOLD_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              supply_ok_i,
  output logic              wr_pulse_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_drive_o
);
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  ctrl_t             ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              wr_en;

  assign ctrl_raw = '{ce_n: ce_ni, oe_n: oe_ni, we_n: we_ni, pwr_ok: supply_ok_i};

  strobe_guard_sync #(.W($bits(ctrl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk_i, .rst_ni, .d_i(ctrl_raw), .q_o(ctrl_s)
  );

  // bus delayed by the same depth so it lines up with the strobes
  strobe_guard_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o(bus_s)
  );

  strobe_guard_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk_i, .rst_ni, .pwr_ok_i(ctrl_s.pwr_ok), .wr_en_o(wr_en)
  );

  strobe_guard_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_qual (
    .clk_i, .rst_ni,
    .ce_n_i(ctrl_s.ce_n), .oe_n_i(ctrl_s.oe_n), .we_n_i(ctrl_s.we_n),
    .wr_en_i(wr_en),
    .addr_i(bus_s[BUS_W-1:DATA_W]), .data_i(bus_s[DATA_W-1:0]),
    .wr_pulse_o, .wr_addr_o, .wr_data_o
  );

  assign rd_drive_o = !ce_ni && !oe_ni && we_ni;
endmodule

// File: tb/strobe_guard_tb_top.sv
module strobe_guard_tb_top;
  localparam int unsigned AW = 13;
  localparam int unsigned DW = 8;
  localparam int unsigned MINL = 3;
  localparam int unsigned HOLD = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, sup = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_pulse, rd_drive;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  strobe_guard #(.ADDR_W(AW), .DATA_W(DW), .MIN_LOW(MINL), .HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .supply_ok_i(sup),
    .wr_pulse_o(wr_pulse), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_drive_o(rd_drive)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one strobe: first enable low, then second (strobe start), hold, release first-rising.
  // then watch 6 falling edges; a pulse must land on the third.
  task automatic strobe(input string tag, input bit we_ctrl,
                        input logic [AW-1:0] a_start, input logic [AW-1:0] a_mid,
                        input logic [DW-1:0] d_start, input logic [DW-1:0] d_last,
                        input int len, input bit oe_glitch, input bit exp_ok);
    int np = 0, pos = 0;
    logic [AW-1:0] a0 = wr_addr, ga = '0;
    logic [DW-1:0] d0 = wr_data, gd = '0;
    @(negedge clk);
    addr = 13'h1fff; data = 8'h00;
    if (we_ctrl) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    addr = a_start; data = d_start;
    if (we_ctrl) we_n = 1'b0; else ce_n = 1'b0;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      addr = a_mid; data = d_last;
      oe_n = !(oe_glitch && i == 1);
    end
    @(negedge clk);
    oe_n = 1'b1;
    if (we_ctrl) we_n = 1'b1; else ce_n = 1'b1;
    addr = 13'h0aaa; data = 8'h5a;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) begin ce_n = 1'b1; we_n = 1'b1; end
      if (wr_pulse) begin np++; pos = i; ga = wr_addr; gd = wr_data; end
    end
    chk({tag, " pulse count"}, np, exp_ok ? 1 : 0);
    if (exp_ok) begin
      chk({tag, " pulse latency"}, pos, 3);
      chk({tag, " addr"}, ga, a_start);
      chk({tag, " data"}, gd, (len > 1) ? d_last : d_start);
    end else begin
      chk({tag, " R10 addr held"}, wr_addr, a0);
      chk({tag, " R10 data held"}, wr_data, d0);
    end
  endtask

  task automatic t_reset();
    #1; chk("R1 pulse in reset", wr_pulse, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse", wr_pulse, 0);
    chk("R1 addr", wr_addr, 0);
    chk("R1 data", wr_data, 0);
    repeat (HOLD + 10) @(negedge clk);
  endtask

  task automatic t_read_drive();
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; #1; chk("R11 read", rd_drive, 1);
    we_n = 0; #1; chk("R11 we low", rd_drive, 0);
    we_n = 1; oe_n = 1; #1; chk("R11 oe high", rd_drive, 0);
    oe_n = 0; ce_n = 1; #1; chk("R11 ce high", rd_drive, 0);
    oe_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_supply();
    @(negedge clk); sup = 1'b0;
    repeat (4) @(negedge clk);
    strobe("R8 supply low", 1'b1, 13'h0123, 13'h0123, 8'h11, 8'h11, 4, 1'b0, 1'b0);
    sup = 1'b1;
    repeat (3) @(negedge clk);
    strobe("R9 inside holdoff", 1'b1, 13'h0124, 13'h0124, 8'h12, 8'h12, 4, 1'b0, 1'b0);
    repeat (HOLD + 5) @(negedge clk);
    strobe("R9 after holdoff", 1'b1, 13'h0125, 13'h0125, 8'h13, 8'h13, 4, 1'b0, 1'b1);
    // short dip restarts the timer
    sup = 1'b0; @(negedge clk); @(negedge clk); sup = 1'b1;
    repeat (4) @(negedge clk);
    strobe("R9 restart", 1'b1, 13'h0126, 13'h0126, 8'h14, 8'h14, 4, 1'b0, 1'b0);
    repeat (HOLD + 5) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_read_drive();
    strobe("R2 we-controlled", 1'b1, 13'h1234, 13'h1234, 8'ha5, 8'ha5, 4, 1'b0, 1'b1);
    strobe("R3 ce-controlled", 1'b0, 13'h0042, 13'h0042, 8'h3c, 8'h3c, 4, 1'b0, 1'b1);
    strobe("R4 addr at start", 1'b1, 13'h0777, 13'h1555, 8'h01, 8'h01, 5, 1'b0, 1'b1);
    strobe("R5 data at end", 1'b0, 13'h0888, 13'h0888, 8'h22, 8'hc7, 5, 1'b0, 1'b1);
    strobe("R6 oe low inhibit", 1'b1, 13'h0999, 13'h0999, 8'h77, 8'h77, 5, 1'b1, 1'b0);
    strobe("R7 too short", 1'b1, 13'h0abc, 13'h0abc, 8'h88, 8'h88, MINL - 1, 1'b0, 1'b0);
    strobe("R7 exact min", 1'b0, 13'h0abd, 13'h0abd, 8'h89, 8'h89, MINL, 1'b0, 1'b1);
    t_supply();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule